// File: doc/BRIEF.md
# Strobe-Paced Buffer Address Counter

This block owns the address of a 4 KB byte buffer that a local controller and an external host share. In direct mode the controller drives the buffer. The buffer address is simply the controller's address bus, with no register in between. The controller then raises the DMA mode input. At that point the address the controller last presented is captured. From then on, every falling edge of the host strobe moves the address forward by one. The host can therefore stream bytes into or out of the buffer at up to 1 MHz with no processor involvement. The host gets no wait signal and never has to wait.

The counter is built from three chained 4-bit preset counters. The host strobe is asynchronous. It is brought into the system clock domain through a synchronizer, and the falling-edge detector drives a small state machine. The states are DIRECT, DMA_HIGH (DMA mode, strobe high) and DMA_LOW (DMA mode, inside a strobe-low window). The transitions are:

- ENTER: DIRECT to DMA_HIGH when DMA mode is sampled high.
- FALL: DMA_HIGH to DMA_LOW on a detected strobe fall. This transition is the one that advances the address and commits a host write.
- RISE: DMA_LOW to DMA_HIGH when the synchronized strobe is high again.
- LEAVE: either DMA state to DIRECT when DMA mode is sampled low.

The block also does three other jobs. It gates writes into the buffer, so that only the side that owns the buffer can write. It steers the read data to the controller or to the host. It generates an odd-parity bit for the byte offered to the host.

Top module: `strobe_dma_addr`

## Requirements
- R1: After reset the block is in direct mode, `ovf_flag` is 0, and `buf_addr` equals `ctl_addr`.
- R2: In direct mode `buf_addr` equals `ctl_addr` in the same cycle, for every 12-bit address value.
- R3: The clock edge that first samples `dma_mode` high freezes `buf_addr` at the `ctl_addr` value of that cycle. Later changes to `ctl_addr` have no effect while DMA mode lasts.
- R4: In DMA mode, each falling edge of `host_strobe_n` advances `buf_addr` by exactly one. The change appears no later than the third clock edge after the fall. A strobe held low or high does not advance it again.
- R5: The address wraps from 0xFFF to 0x000. The wrap sets `ovf_flag`, which stays set through further strobes and through direct mode. It is cleared on the clock edge that enters DMA mode.
- R6: In DMA mode with `host_rd` = 0, each strobe fall writes `host_din` into the buffer at the address held before the advance. With `host_rd` = 1, strobes write nothing.
- R7: `ctl_we` writes `ctl_wdata` at `ctl_addr` only in direct mode. In DMA mode it is ignored, and `ctl_rdata` reads 0x00.
- R8: `host_dout` equals the buffer byte at `buf_addr` whenever `host_rd` = 1, in either mode. It is 0x00 when `host_rd` = 0.
- R9: `host_par` is 1 exactly when `host_dout` has an even number of one bits. This makes the nine bits odd in total.
- R10: In direct mode, host strobes neither move the address nor write the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_mode | input | 1 | 1 = host strobe paces the address, 0 = controller address passes through |
| ctl_addr | input | 12 | Controller address, also the preset value for the counter |
| ctl_wdata | input | 8 | Controller write data |
| ctl_we | input | 1 | Controller write enable (effective in direct mode only) |
| ctl_rdata | output | 8 | Buffer byte to the controller, 0x00 during DMA |
| host_strobe_n | input | 1 | Asynchronous host strobe, active low |
| host_rd | input | 1 | 1 = host reads, 0 = host writes |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Buffer byte to the host when reading |
| host_par | output | 1 | Odd-parity bit for `host_dout` |
| buf_addr | output | 12 | Current buffer address |
| ovf_flag | output | 1 | Sticky address wrap flag |

## Verification
Suppose the captured counter value is wrong when DMA starts. Then `buf_addr` differs from the last controller address on the first cycle of DMA mode, and every later host byte lands at or comes from the wrong place. A missed or doubled strobe edge shows as an address off by one no more than three cycles after the strobe falls. The same fault shifts the following bytes by one place in the buffer, so a write burst read back in direct mode exposes it. A wrong carry between nibbles, or a wrong wrap, shows at the 0xF/0x0 nibble crossings and at 0xFFF. An overflow flag that clears at the wrong time shows in the cycle after a strobe, or after leaving DMA mode.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    typedef enum logic [1:0] {
        ST_DIRECT   = 2'd0,
        ST_DMA_HIGH = 2'd1,
        ST_DMA_LOW  = 2'd2
    } dstate_t;
endpackage

// File: rtl/dmaq_strobe_sync.sv
module dmaq_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic strb_low,
    output logic strb_fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign strb_low  = ~sync_q[STAGES-1];
    assign strb_fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dmaq_nibble.sv
module dmaq_nibble #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] preset,
    input  logic         cin,
    output logic [W-1:0] q,
    output logic         cout
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= preset;
        else if (cin)
            q <= q + 1'b1;
    end

    assign cout = cin & (&q);
endmodule

// File: rtl/dmaq_ram.sv
module dmaq_ram #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
    import dmaq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dma_mode,
    input  logic strb_fall,
    input  logic strb_low,
    output logic direct,
    output logic step,
    output logic entering
);
    dstate_t state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DIRECT;
        end else begin
            unique case (state)
                ST_DIRECT:   if (dma_mode) state <= ST_DMA_HIGH;
                ST_DMA_HIGH: if (!dma_mode) state <= ST_DIRECT;
                             else if (strb_fall) state <= ST_DMA_LOW;
                ST_DMA_LOW:  if (!dma_mode) state <= ST_DIRECT;
                             else if (!strb_low) state <= ST_DMA_HIGH;
                default:     state <= ST_DIRECT;
            endcase
        end
    end

    always_comb begin
        direct   = 1'b0;
        step     = 1'b0;
        entering = 1'b0;
        unique case (state)
            ST_DIRECT: begin
                direct   = 1'b1;
                entering = dma_mode;
            end
            ST_DMA_HIGH: step = dma_mode & strb_fall;
            ST_DMA_LOW:  step = 1'b0;
            default:     direct = 1'b1;
        endcase
    end
endmodule

// File: rtl/strobe_dma_addr.sv
module strobe_dma_addr #(
    parameter int NIB_W       = 4,
    parameter int NIB_N       = 3,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dma_mode,
    input  logic [NIB_W*NIB_N-1:0]   ctl_addr,
    input  logic [DATA_W-1:0]        ctl_wdata,
    input  logic                     ctl_we,
    output logic [DATA_W-1:0]        ctl_rdata,
    input  logic                     host_strobe_n,
    input  logic                     host_rd,
    input  logic [DATA_W-1:0]        host_din,
    output logic [DATA_W-1:0]        host_dout,
    output logic                     host_par,
    output logic [NIB_W*NIB_N-1:0]   buf_addr,
    output logic                     ovf_flag
);
    localparam int ADDR_W = NIB_W * NIB_N;

    logic              strb_low, strb_fall;
    logic              direct, step, entering;
    logic [ADDR_W-1:0] cnt;
    logic [NIB_N:0]    carry;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    dmaq_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_strobe_n),
        .strb_low(strb_low), .strb_fall(strb_fall)
    );

    dmaq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
        .strb_fall(strb_fall), .strb_low(strb_low),
        .direct(direct), .step(step), .entering(entering)
    );

    assign carry[0] = step;

    for (genvar g = 0; g < NIB_N; g++) begin : g_nib
        dmaq_nibble #(.W(NIB_W)) u_nib (
            .clk(clk), .rst_n(rst_n), .load(direct),
            .preset(ctl_addr[g*NIB_W +: NIB_W]),
            .cin(carry[g]),
            .q(cnt[g*NIB_W +: NIB_W]),
            .cout(carry[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (entering)
            ovf_flag <= 1'b0;
        else if (carry[NIB_N])
            ovf_flag <= 1'b1;
    end

    assign buf_addr  = direct ? ctl_addr : cnt;
    assign mem_we    = direct ? ctl_we : (step & ~host_rd);
    assign mem_wdata = direct ? ctl_wdata : host_din;

    dmaq_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk(clk), .we(mem_we), .addr(buf_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    assign ctl_rdata = direct  ? mem_rdata : '0;
    assign host_dout = host_rd ? mem_rdata : '0;
    assign host_par  = ~(^host_dout);
endmodule

// File: rtl/dmaq_checker.sv
module dmaq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        dma_mode,
    input logic [11:0] ctl_addr,
    input logic [11:0] buf_addr,
    input logic [7:0]  ctl_rdata,
    input logic [7:0]  host_dout,
    input logic        host_par,
    input logic        ovf_flag
);
    // R2: with no DMA mode sampled, address passes through
    a_r2_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dma_mode) |-> buf_addr == ctl_addr);

    // R4: inside a DMA run the address holds or advances by one
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dma_mode) && $past(dma_mode, 2)) |->
        (buf_addr == $past(buf_addr) || buf_addr == 12'($past(buf_addr) + 12'd1)));

    // R5: overflow flag is sticky except at DMA entry
    a_r5_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag) && !($past(dma_mode) && !$past(dma_mode, 2))) |-> ovf_flag);

    // R7: controller side is cut off during DMA
    a_r7_ctl_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dma_mode) |-> ctl_rdata == 8'h00);

    // R9: nine host bits carry odd parity
    a_r9_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({host_dout, host_par}) % 2) == 1);
endmodule

bind strobe_dma_addr dmaq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .ctl_addr(ctl_addr),
    .buf_addr(buf_addr), .ctl_rdata(ctl_rdata), .host_dout(host_dout),
    .host_par(host_par), .ovf_flag(ovf_flag)
);

// File: tb/strobe_dma_addr_test.sv
`timescale 1ns/1ps
module strobe_dma_addr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_mode = 1'b0;
    logic [11:0] ctl_addr = 12'h000;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_rdata;
    logic        host_strobe_n = 1'b1;
    logic        host_rd = 1'b1;
    logic [7:0]  host_din = 8'h00;
    logic [7:0]  host_dout;
    logic        host_par;
    logic [11:0] buf_addr;
    logic        ovf_flag;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strobe_dma_addr uut (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
        .host_strobe_n(host_strobe_n), .host_rd(host_rd), .host_din(host_din),
        .host_dout(host_dout), .host_par(host_par), .buf_addr(buf_addr),
        .ovf_flag(ovf_flag)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + (a >> 8)) & 255);
    endfunction

    function automatic logic exp_par(logic [7:0] d);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        return (ones % 2 == 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        host_strobe_n = 1'b0;
        tick(5);
        host_strobe_n = 1'b1;
        tick(5);
    endtask

    task automatic enter_dma(logic [11:0] a);
        ctl_addr = a;
        dma_mode = 1'b1;
        tick(1);
    endtask

    task automatic leave_dma();
        dma_mode = 1'b0;
        tick(1);
    endtask

    task automatic read_ctl(logic [11:0] a, logic [7:0] e, string req);
        ctl_addr = a;
        #1;
        check(ctl_rdata == e, req, ctl_rdata, e);
    endtask

    initial begin
        tick(3);
        ctl_addr = 12'h123;
        #1;
        check(buf_addr == 12'h123, "R1 addr follows", buf_addr, 12'h123);
        check(ovf_flag == 1'b0, "R1 ovf clear", ovf_flag, 0);
        rst_n = 1'b1;
        tick(1);

        // fill buffer from controller side, R2 sweep of all addresses
        ctl_we = 1'b1;
        for (int a = 0; a < 4096; a++) begin
            ctl_addr = 12'(a);
            ctl_wdata = pat(a);
            tick(1);
        end
        ctl_we = 1'b0;
        host_rd = 1'b1;
        for (int a = 0; a < 4096; a++) begin
            ctl_addr = 12'(a);
            #1;
            check(buf_addr == 12'(a), "R2 direct address", buf_addr, a);
            check(ctl_rdata == pat(a), "R7 direct read", ctl_rdata, pat(a));
            check(host_dout == pat(a), "R8 host read", host_dout, pat(a));
            check(host_par == exp_par(host_dout), "R9 parity", host_par, exp_par(host_dout));
            tick(1);
        end

        // R3 freeze, R4 stepping, R5 wrap in a read stream
        enter_dma(12'hFF0);
        ctl_addr = 12'h005;
        #1;
        check(buf_addr == 12'hFF0, "R3 frozen address", buf_addr, 12'hFF0);
        check(ctl_rdata == 8'h00, "R7 ctl isolated", ctl_rdata, 0);
        for (int k = 0; k < 32; k++) begin
            int ea;
            ea = (12'hFF0 + k) & 12'hFFF;
            check(host_dout == pat(ea), "R8 stream read", host_dout, pat(ea));
            check(host_par == exp_par(host_dout), "R9 stream parity", host_par, exp_par(host_dout));
            ctl_addr = 12'(k * 97);
            pulse();
            ea = (12'hFF0 + k + 1) & 12'hFFF;
            check(buf_addr == 12'(ea), "R4 one step per strobe", buf_addr, ea);
            check(ovf_flag == (k >= 15), "R5 wrap flag", ovf_flag, (k >= 15));
        end
        // held-low strobe: single advance only
        host_strobe_n = 1'b0;
        tick(12);
        check(buf_addr == 12'h011, "R4 held low no extra step", buf_addr, 12'h011);
        host_strobe_n = 1'b1;
        tick(12);
        check(buf_addr == 12'h011, "R4 held high no step", buf_addr, 12'h011);

        // R7 controller write ignored in DMA
        ctl_addr = 12'h7F0;
        ctl_wdata = 8'hAA;
        ctl_we = 1'b1;
        tick(3);
        ctl_we = 1'b0;
        leave_dma();
        check(ovf_flag == 1'b1, "R5 sticky in direct", ovf_flag, 1);
        read_ctl(12'h7F0, pat(12'h7F0), "R7 DMA ctl write ignored");

        // R6 host write burst, R5 clear on entry
        host_rd = 1'b0;
        enter_dma(12'h400);
        #1;
        check(ovf_flag == 1'b0, "R5 cleared on entry", ovf_flag, 0);
        check(host_dout == 8'h00, "R8 dout idle on write", host_dout, 0);
        for (int k = 0; k < 16; k++) begin
            host_din = 8'(8'h50 + k);
            pulse();
        end
        check(buf_addr == 12'h410, "R4 burst end address", buf_addr, 12'h410);
        leave_dma();
        for (int k = 0; k < 16; k++)
            read_ctl(12'(12'h400 + k), 8'(8'h50 + k), "R6 host write data");
        read_ctl(12'h410, pat(12'h410), "R6 no write past burst");
        read_ctl(12'h3FF, pat(12'h3FF), "R6 no write before burst");

        // R6 reads do not write
        host_rd = 1'b1;
        host_din = 8'hEE;
        enter_dma(12'h500);
        for (int k = 0; k < 4; k++) pulse();
        leave_dma();
        for (int k = 0; k < 4; k++)
            read_ctl(12'(12'h500 + k), pat(12'h500 + k), "R6 read strobes no write");

        // R10 strobes in direct mode
        host_rd = 1'b0;
        host_din = 8'h11;
        ctl_addr = 12'h600;
        for (int k = 0; k < 3; k++) pulse();
        #1;
        check(buf_addr == 12'h600, "R10 direct address unmoved", buf_addr, 12'h600);
        read_ctl(12'h600, pat(12'h600), "R10 direct no host write");
        check(ovf_flag == 1'b0, "R10 no flag", ovf_flag, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule